// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block keeps the transfer state of one channel of a classic system DMA controller. The host programs a 16-bit start offset, a 16-bit transfer count and an 8-bit page. Programming the offset or the count also primes the working copy of that value. Each accepted transfer acknowledge then moves the working offset one unit up or down and takes one from the working count. The page never moves, and the 16-bit offset wraps inside its page. The count is written as the number of transfer units minus one, so terminal count comes on the acknowledge that finds the working count already at zero.

At terminal count the block sends out a one-cycle pulse and sets a sticky done flag, which the host clears with a strobe. If auto-initialize is selected, the working offset and count are reloaded from the programmed copies and the channel keeps running. If not, the channel sets its own mask and ignores acknowledges until the host clears the mask. A build parameter makes the channel a byte channel or a word channel. On a word channel each unit is a 16-bit word, and the offset supplies physical address bits 16:1.

The block carries no data, so it has no valid/ready stream. Every pin is a plain level or a single-cycle strobe, and nothing at the edge can apply back-pressure. A transfer acknowledge that is not accepted is dropped and is never held over.

Top module: `dmach_seq`

## Requirements
- R1: After reset the channel is masked, done and tc are 0, and the working offset, working count, programmed copies and page are all zero, so phys_addr reads 0.
- R2: With a programmed count N, the (N+1)-th accepted acknowledge is the terminal one. tc is high for exactly the one cycle after the clock edge that accepted it, and done is set at that same edge.
- R3: With mode_down low, each accepted acknowledge adds 1 to the working offset. With mode_down high, it subtracts 1.
- R4: With mode_auto high, a terminal acknowledge reloads the working offset and count from the programmed copies, and the channel stays unmasked.
- R5: With mode_auto low, a terminal acknowledge steps the offset as usual and sets the mask. Later acknowledges leave phys_addr unchanged until mask_wr with mask_val=0 clears the mask.
- R6: done stays set until a done_clr strobe clears it. A terminal acknowledge in the same cycle as done_clr leaves done set.
- R7: An acknowledge is ignored while the channel is masked or ctrl_en is low.
- R8: ld_base_addr or ld_base_cnt writes wr_data into both the programmed and working copy of that value. An acknowledge in the same cycle as either load is dropped.
- R9: ld_page writes wr_data[7:0] to the page, which is the only thing that ever changes it. Stepping the offset past 0xFFFF or below 0x0000 wraps within 16 bits and never changes the page.
- R10: On a byte channel (WORD_CH=0) phys_addr = {page, offset}. On a word channel (WORD_CH=1) phys_addr = {page[7:1], offset, 1'b0}, so bit 16 comes from the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; low blocks acknowledges |
| wr_data | input | DATA_W | Host write data for offset, count and page loads |
| ld_base_addr | input | 1 | Load programmed and working offset |
| ld_base_cnt | input | 1 | Load programmed and working count |
| ld_page | input | 1 | Load page byte from wr_data[PAGE_W-1:0] |
| mask_wr | input | 1 | Write the channel mask |
| mask_val | input | 1 | Mask value written by mask_wr |
| mode_auto | input | 1 | Auto-initialize select |
| mode_down | input | 1 | Offset decrements when high |
| xfer_ack | input | 1 | Transfer acknowledge strobe, one unit per cycle |
| done_clr | input | 1 | Clear the done flag |
| phys_addr | output | PAGE_W+DATA_W | Physical byte address |
| tc | output | 1 | Terminal-count pulse |
| done | output | 1 | Sticky completion flag |
| masked | output | 1 | Channel mask state |

## Verification
The bench builds two copies of the block side by side from the same stimulus: one with WORD_CH=0 and one with WORD_CH=1, both at the default 16-bit offset and 8-bit page. Running the two variants together puts the byte and word address layouts under the same offset walks, including wraps in both directions. In the word layout the offset carries into bit 16 and page bit 0 drops out, and both copies must agree on tc, done and masked. Small programmed counts (0 to 4) bring the terminal and reload cases within a few cycles.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dmach_dir_e;
  typedef enum logic [1:0] {
    STEP_IDLE   = 2'd0,
    STEP_ADV    = 2'd1,
    STEP_RELOAD = 2'd2
  } dmach_step_e;
endpackage

// File: rtl/dmach_reg_pair.sv
module dmach_reg_pair
  import dmach_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  dmach_step_e  step,
  input  dmach_dir_e   dir,
  output logic [W-1:0] base,
  output logic [W-1:0] cur
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cur  <= '0;
    end else if (load) begin
      base <= load_val;
      cur  <= load_val;
    end else begin
      unique case (step)
        STEP_ADV:    cur <= (dir == DIR_DOWN) ? cur - ONE : cur + ONE;
        STEP_RELOAD: cur <= base;
        default:     cur <= cur;
      endcase
    end
  end

  // R8: a load primes both copies
  a_r8_load_both: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(load_val) && base == $past(load_val)));
  // R4: reload restores the programmed copy
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_RELOAD && !load) |=> cur == $past(base));
endmodule

// File: rtl/dmach_addr_fmt.sv
module dmach_addr_fmt #(
  parameter int OFS_W   = 16,
  parameter int PAGE_W  = 8,
  parameter bit WORD_CH = 1'b0
) (
  input  logic [PAGE_W-1:0]       page,
  input  logic [OFS_W-1:0]        ofs,
  output logic [PAGE_W+OFS_W-1:0] addr
);
  generate
    if (WORD_CH) begin : g_word
      logic unused_page_lsb;
      assign unused_page_lsb = page[0];
      assign addr = {page[PAGE_W-1:1], ofs, 1'b0};
    end else begin : g_byte
      assign addr = {page, ofs};
    end
  endgenerate
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
  import dmach_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PAGE_W  = 8,
  parameter bit WORD_CH = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     ld_base_addr,
  input  logic                     ld_base_cnt,
  input  logic                     ld_page,
  input  logic                     mask_wr,
  input  logic                     mask_val,
  input  logic                     mode_auto,
  input  logic                     mode_down,
  input  logic                     xfer_ack,
  input  logic                     done_clr,
  output logic [PAGE_W+DATA_W-1:0] phys_addr,
  output logic                     tc,
  output logic                     done,
  output logic                     masked
);
  localparam int ADDR_W = PAGE_W + DATA_W;

  logic [DATA_W-1:0] ofs_base, ofs_cur, cnt_base, cnt_cur;
  logic [PAGE_W-1:0] page_q;
  logic              accept, last;
  dmach_step_e       step;
  dmach_dir_e        ofs_dir;

  assign accept  = xfer_ack && !masked && ctrl_en && !ld_base_addr && !ld_base_cnt;
  assign last    = (cnt_cur == '0);
  assign ofs_dir = mode_down ? DIR_DOWN : DIR_UP;

  always_comb begin
    if (!accept)                step = STEP_IDLE;
    else if (last && mode_auto) step = STEP_RELOAD;
    else                        step = STEP_ADV;
  end

  dmach_reg_pair #(.W(DATA_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .load(ld_base_addr), .load_val(wr_data),
    .step(step), .dir(ofs_dir), .base(ofs_base), .cur(ofs_cur)
  );

  dmach_reg_pair #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld_base_cnt), .load_val(wr_data),
    .step(step), .dir(DIR_DOWN), .base(cnt_base), .cur(cnt_cur)
  );

  logic unused_cnt_base;
  assign unused_cnt_base = ^cnt_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      tc     <= 1'b0;
      done   <= 1'b0;
      masked <= 1'b1;
    end else begin
      if (ld_page) page_q <= wr_data[PAGE_W-1:0];
      tc <= accept && last;
      if (accept && last)  done <= 1'b1;
      else if (done_clr)   done <= 1'b0;
      if (mask_wr)                           masked <= mask_val;
      else if (accept && last && !mode_auto) masked <= 1'b1;
    end
  end

  dmach_addr_fmt #(.OFS_W(DATA_W), .PAGE_W(PAGE_W), .WORD_CH(WORD_CH)) u_fmt (
    .page(page_q), .ofs(ofs_cur), .addr(phys_addr)
  );

  // R7: blocked acknowledges leave the address alone
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !ld_base_addr && !ld_page) |=> $stable(phys_addr));
  // R9: page bits above the offset move only on a page load
  a_r9_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_page |=> $stable(phys_addr[ADDR_W-1:DATA_W+1]));
  // R2: a terminal pulse always comes with done
  a_r2_tc_done: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> done);
  // R5: single-cycle mode masks itself at terminal count
  a_r5_selfmask: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last && !mode_auto && !mask_wr) |=> masked);
  // R6: done is sticky
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);
endmodule

// File: tb/test_dmach_seq.sv
module test_dmach_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ld_base_addr = 1'b0, ld_base_cnt = 1'b0, ld_page = 1'b0;
  logic        mask_wr = 1'b0, mask_val = 1'b0;
  logic        mode_auto = 1'b0, mode_down = 1'b0;
  logic        xfer_ack = 1'b0, done_clr = 1'b0;
  logic [23:0] addr_b, addr_w;
  logic        tc_b, done_b, masked_b, tc_w, done_w, masked_w;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dmach_seq #(.WORD_CH(1'b0)) i_dmach_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .wr_data(wr_data),
    .ld_base_addr(ld_base_addr), .ld_base_cnt(ld_base_cnt), .ld_page(ld_page),
    .mask_wr(mask_wr), .mask_val(mask_val), .mode_auto(mode_auto),
    .mode_down(mode_down), .xfer_ack(xfer_ack), .done_clr(done_clr),
    .phys_addr(addr_b), .tc(tc_b), .done(done_b), .masked(masked_b)
  );

  dmach_seq #(.WORD_CH(1'b1)) i_dmach_seq_word (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .wr_data(wr_data),
    .ld_base_addr(ld_base_addr), .ld_base_cnt(ld_base_cnt), .ld_page(ld_page),
    .mask_wr(mask_wr), .mask_val(mask_val), .mode_auto(mode_auto),
    .mode_down(mode_down), .xfer_ack(xfer_ack), .done_clr(done_clr),
    .phys_addr(addr_w), .tc(tc_w), .done(done_w), .masked(masked_w)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [15:0] v);
    @(negedge clk);
    wr_data = v;
    ld_base_addr = (which == 0);
    ld_base_cnt  = (which == 1);
    ld_page      = (which == 2);
    @(negedge clk);
    ld_base_addr = 1'b0; ld_base_cnt = 1'b0; ld_page = 1'b0;
  endtask

  task automatic set_mask(input logic v);
    @(negedge clk); mask_wr = 1'b1; mask_val = v;
    @(negedge clk); mask_wr = 1'b0;
  endtask

  task automatic clr_done;
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic acks(input int n, output int tcs);
    tcs = 0;
    xfer_ack = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tcs += int'(tc_b);
    end
    xfer_ack = 1'b0;
  endtask

  // offset, page, count, down, auto, acks, exp byte addr, exp word addr, exp tc pulses, exp done, exp masked
  typedef struct packed {
    logic [15:0] ofs; logic [7:0] page; logic [15:0] cnt;
    logic down; logic autoi; logic [7:0] nack;
    logic [23:0] eb; logic [23:0] ew; logic [7:0] etc; logic edone; logic emask;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h1000, 8'h12, 16'd3, 1'b0, 1'b0, 8'd2, 24'h121002, 24'h122004, 8'd0, 1'b0, 1'b0}, // R2 R3 before tc
    '{16'h1000, 8'h12, 16'd3, 1'b0, 1'b0, 8'd4, 24'h121004, 24'h122008, 8'd1, 1'b1, 1'b1}, // R2 R5
    '{16'h1000, 8'h12, 16'd3, 1'b0, 1'b0, 8'd6, 24'h121004, 24'h122008, 8'd1, 1'b1, 1'b1}, // R5 ignored
    '{16'h0002, 8'h34, 16'd1, 1'b1, 1'b0, 8'd1, 24'h340001, 24'h340002, 8'd0, 1'b0, 1'b0}, // R3 down
    '{16'hFFFF, 8'h05, 16'd4, 1'b0, 1'b0, 8'd2, 24'h050001, 24'h040002, 8'd0, 1'b0, 1'b0}, // R9 wrap up
    '{16'h0000, 8'h05, 16'd4, 1'b1, 1'b0, 8'd1, 24'h05FFFF, 24'h05FFFE, 8'd0, 1'b0, 1'b0}, // R9 R10 wrap down
    '{16'h2000, 8'h01, 16'd2, 1'b0, 1'b1, 8'd3, 24'h012000, 24'h004000, 8'd1, 1'b1, 1'b0}, // R4 reload
    '{16'h2000, 8'h01, 16'd2, 1'b0, 1'b1, 8'd4, 24'h012001, 24'h004002, 8'd1, 1'b1, 1'b0}, // R4 runs on
    '{16'h0010, 8'hAB, 16'd0, 1'b1, 1'b1, 8'd5, 24'hAB0010, 24'hAA0020, 8'd5, 1'b1, 1'b0}  // R4 count 0
  };

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int tcs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 masked", 32'(masked_b), 32'd1);
    check("R1 done", 32'(done_b), 32'd0);
    check("R1 tc", 32'(tc_b), 32'd0);
    check("R1 addr", 32'(addr_b), 32'h0);
    ctrl_en = 1'b1;

    for (int k = 0; k < NV; k++) begin
      set_mask(1'b1);
      clr_done();
      mode_down = VECS[k].down;
      mode_auto = VECS[k].autoi;
      wr(2, {8'h00, VECS[k].page});
      wr(0, VECS[k].ofs);
      wr(1, VECS[k].cnt);
      set_mask(1'b0);
      acks(int'(VECS[k].nack), tcs);
      check($sformatf("R3/R9 vec%0d byte addr", k), 32'(addr_b), 32'(VECS[k].eb));
      check($sformatf("R10 vec%0d word addr", k), 32'(addr_w), 32'(VECS[k].ew));
      check($sformatf("R2 vec%0d tc pulses", k), 32'(tcs), 32'(VECS[k].etc));
      check($sformatf("R6 vec%0d done", k), 32'(done_b), 32'(VECS[k].edone));
      check($sformatf("R5 vec%0d masked", k), 32'(masked_b), 32'(VECS[k].emask));
      check($sformatf("R10 vec%0d word done", k), 32'(done_w), 32'(VECS[k].edone));
    end

    // R6: done still set after idle cycles, cleared by done_clr
    repeat (4) @(negedge clk);
    check("R6 sticky", 32'(done_b), 32'd1);
    clr_done();
    check("R6 cleared", 32'(done_b), 32'd0);

    // R7: disabled controller ignores acknowledges
    set_mask(1'b1);
    mode_auto = 1'b0; mode_down = 1'b0;
    wr(2, 16'h0077);
    wr(0, 16'h4000);
    wr(1, 16'd10);
    set_mask(1'b0);
    ctrl_en = 1'b0;
    acks(3, tcs);
    check("R7 disabled", 32'(addr_b), 32'h774000);
    ctrl_en = 1'b1;
    set_mask(1'b1);
    acks(3, tcs);
    check("R7 masked", 32'(addr_b), 32'h774000);
    set_mask(1'b0);
    acks(1, tcs);
    check("R7 unmasked steps", 32'(addr_b), 32'h774001);

    // R8: an acknowledge with a load is dropped and the load lands
    @(negedge clk);
    wr_data = 16'h3000; ld_base_addr = 1'b1; xfer_ack = 1'b1;
    @(negedge clk);
    ld_base_addr = 1'b0; xfer_ack = 1'b0;
    check("R8 load wins", 32'(addr_b), 32'h773000);
    // count was 9 after one step: 10 more acks reach terminal count
    acks(10, tcs);
    check("R8 count untouched", 32'(tcs), 32'd1);
    check("R8 addr after run", 32'(addr_b), 32'h77300A);

    // R6: terminal acknowledge with done_clr leaves done set
    clr_done();
    set_mask(1'b0);
    wr(1, 16'd0);
    @(negedge clk);
    xfer_ack = 1'b1; done_clr = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0; done_clr = 1'b0;
    check("R6 set wins", 32'(done_b), 32'd1);
    check("R2 tc pulse", 32'(tc_b), 32'd1);
    @(negedge clk);
    check("R2 tc one cycle", 32'(tc_b), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule